// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind an I2C bus-event decoder and decides, byte by byte, whether the local target is being selected. It receives single-cycle event strobes for start, repeated start and stop, plus a strobe for each received byte. It tracks where each byte falls in the transfer, so only the address byte, or the two-byte address in 10-bit mode, is compared.

Configuration inputs set the mode and the behaviour. One picks 7-bit or 10-bit matching. Another carries the 10-bit own address. The remaining inputs enable general-call recognition, disable the target entirely, and limit stop reporting to transfers that selected this target by its own address.

The outputs are one-cycle pulses, each registered one clock after the event that causes it. They are: an own-address match, an acknowledge request for the address phase, a general-call hit, and a qualified stop-detect interrupt.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After a synchronous reset, every output pulse is 0 and the addressed flag is clear, so a stop seen with stop qualification on produces no interrupt.
- R2: In 7-bit mode, when the first byte after a start or repeated start has bits [7:1] equal to own_addr[6:0], addr_match and ack_req both pulse for exactly one cycle, one clock after the byte strobe. Bit 0 (read/write) and own_addr[9:7] do not affect this.
- R3: In 7-bit mode, a first byte whose bits [7:3] are 5'b11110 (a 10-bit header) produces no match, acknowledge or general-call pulse, whatever the own address is.
- R4: In 10-bit mode, a first byte of 5'b11110, own_addr[9:8], 0 (write) pulses ack_req alone. If the next byte equals own_addr[7:0], addr_match and ack_req pulse; any other second byte produces nothing.
- R5: In 10-bit mode, a read header (5'b11110, own_addr[9:8], 1) after a repeated start, in a transfer already matched, pulses addr_match and ack_req. Without a prior match since the last start, it produces nothing.
- R6: A first byte of 0x00 pulses ack_req and gc_hit, but not addr_match, when gc_en is 1. When gc_en is 0 it produces nothing.
- R7: While slave_dis is 1, no byte produces addr_match, ack_req or gc_hit.
- R8: With stop_qual_en at 0, every stop strobe produces a one-cycle stop_irq pulse one clock later.
- R9: With stop_qual_en at 1, stop_irq pulses only if an own-address match occurred since the last start. A general call does not count.
- R10: A start clears the addressed flag; a repeated start keeps it. A stop clears it after the stop has been qualified.
- R11: Bytes after the address phase of a transfer never produce match, acknowledge or general-call pulses, even when they equal the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start condition strobe |
| ev_rstart | input | 1 | Repeated start condition strobe |
| ev_stop | input | 1 | Stop condition strobe |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte, first bit on the wire in bit 7 |
| ten_bit_mode | input | 1 | 1 selects 10-bit matching, 0 selects 7-bit |
| own_addr | input | 10 | Own target address |
| gc_en | input | 1 | Enables general-call recognition |
| slave_dis | input | 1 | Suppresses all matching |
| stop_qual_en | input | 1 | Limits stop_irq to transfers with an own-address match |
| addr_match | output | 1 | Own-address match pulse |
| ack_req | output | 1 | Acknowledge request pulse for an address byte |
| gc_hit | output | 1 | General-call acknowledged pulse |
| stop_irq | output | 1 | Qualified stop-detect pulse |

## Verification
The internal state is small: the phase within the transfer and the addressed flag. Each piece of it shows at the ports within one byte or one stop.

A phase stuck in the address position makes a data byte that equals the address produce a spurious match on the next clock. A phase that fails to advance after a 10-bit header loses the match on the low address byte. A wrong addressed flag appears only at a qualified stop, or at a 10-bit read header after a repeated start. The stimulus therefore ends transfers with qualified stops and reuses address values as data.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 10;
    localparam int SHORT_W = 7;
    localparam logic [4:0] TEN_HDR_TAG = 5'b11110;
    localparam logic [BYTE_W-1:0] GC_BYTE = '0;

    // Position of the next received byte within the current transfer.
    typedef enum logic [1:0] {
        PH_SKIP   = 2'd0,   // outside the address phase
        PH_FIRST  = 2'd1,   // next byte is the first after a (repeated) start
        PH_TEN_LO = 2'd2    // next byte is the low half of a 10-bit address
    } phase_t;

    // Classification of one received byte against the configuration.
    typedef struct packed {
        logic is_ten_hdr;   // byte carries the 10-bit header tag
        logic hdr_hi_ok;    // header address bits equal own_addr[9:8]
        logic rw_read;      // read/write bit is read
        logic short_hit;    // 7-bit address equals own_addr[6:0]
        logic low_hit;      // byte equals own_addr[7:0]
        logic is_gc;        // byte is the general-call address with write
    } byte_info_t;

    // Registered result pulses of the address phase.
    typedef struct packed {
        logic match;
        logic ack;
        logic gc;
    } addr_result_t;

    function automatic byte_info_t classify_byte(
        input logic [BYTE_W-1:0] b,
        input logic [ADDR_W-1:0] own
    );
        byte_info_t r;
        r.is_ten_hdr = (b[7:3] == TEN_HDR_TAG);
        r.hdr_hi_ok  = (b[2:1] == own[ADDR_W-1:ADDR_W-2]);
        r.rw_read    = b[0];
        r.short_hit  = (b[7:1] == own[SHORT_W-1:0]);
        r.low_hit    = (b == own[BYTE_W-1:0]);
        r.is_gc      = (b == GC_BYTE);
        return r;
    endfunction

endpackage

// File: rtl/i2c_am_byte_decode.sv
module i2c_am_byte_decode
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [ADDR_W-1:0] own_addr,
    output byte_info_t        info
);

    always_comb begin
        info = classify_byte(byte_data, own_addr);
    end

endmodule

// File: rtl/i2c_am_phase_seq.sv
module i2c_am_phase_seq
    import i2c_am_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ev_start,
    input  logic         ev_rstart,
    input  logic         ev_stop,
    input  logic         byte_valid,
    input  byte_info_t   info,
    input  logic         ten_bit_mode,
    input  logic         gc_en,
    input  logic         slave_dis,
    output addr_result_t result,
    output logic         addressed
);

    phase_t       phase_q, phase_d;
    logic         addr_d;
    addr_result_t res_d;

    always_comb begin
        phase_d = phase_q;
        addr_d  = addressed;
        res_d   = '0;
        if (ev_stop) begin
            phase_d = PH_SKIP;
            addr_d  = 1'b0;
        end else if (ev_start) begin
            phase_d = PH_FIRST;
            addr_d  = 1'b0;
        end else if (ev_rstart) begin
            phase_d = PH_FIRST;
        end else if (byte_valid) begin
            phase_d = PH_SKIP;
            if (!slave_dis) begin
                unique case (phase_q)
                    PH_FIRST: begin
                        if (ten_bit_mode) begin
                            if (info.is_ten_hdr && info.hdr_hi_ok) begin
                                if (!info.rw_read) begin
                                    res_d.ack = 1'b1;
                                    phase_d   = PH_TEN_LO;
                                end else if (addressed) begin
                                    res_d.ack   = 1'b1;
                                    res_d.match = 1'b1;
                                end
                            end else if (info.is_gc && gc_en) begin
                                res_d.ack = 1'b1;
                                res_d.gc  = 1'b1;
                            end
                        end else if (!info.is_ten_hdr) begin
                            if (info.short_hit) begin
                                res_d.ack   = 1'b1;
                                res_d.match = 1'b1;
                                addr_d      = 1'b1;
                            end else if (info.is_gc && gc_en) begin
                                res_d.ack = 1'b1;
                                res_d.gc  = 1'b1;
                            end
                        end
                    end
                    PH_TEN_LO: begin
                        if (info.low_hit) begin
                            res_d.ack   = 1'b1;
                            res_d.match = 1'b1;
                            addr_d      = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_SKIP;
            addressed <= 1'b0;
            result    <= '0;
        end else begin
            phase_q   <= phase_d;
            addressed <= addr_d;
            result    <= res_d;
        end
    end

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        result.match |-> addressed) else $error("match without addressed flag"); // R10

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ev_start && !ev_stop |=> !addressed) else $error("start kept addressed flag"); // R10

endmodule

// File: rtl/i2c_am_stop_qual.sv
module i2c_am_stop_qual (
    input  logic clk,
    input  logic rst,
    input  logic ev_stop,
    input  logic stop_qual_en,
    input  logic addressed,
    output logic stop_irq
);

    always_ff @(posedge clk) begin
        if (rst) stop_irq <= 1'b0;
        else     stop_irq <= ev_stop && (!stop_qual_en || addressed);
    end

    AST_STOP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        ev_stop && stop_qual_en && !addressed |=> !stop_irq) else $error("unqualified stop"); // R9

    AST_STOP_PLAIN: assert property (@(posedge clk) disable iff (rst)
        ev_stop && !stop_qual_en |=> stop_irq) else $error("stop not reported"); // R8

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              ten_bit_mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              slave_dis,
    input  logic              stop_qual_en,
    output logic              addr_match,
    output logic              ack_req,
    output logic              gc_hit,
    output logic              stop_irq
);

    byte_info_t   info;
    addr_result_t result;
    logic         addressed;

    i2c_am_byte_decode u_decode (
        .byte_data (byte_data),
        .own_addr  (own_addr),
        .info      (info)
    );

    i2c_am_phase_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .ev_start     (ev_start),
        .ev_rstart    (ev_rstart),
        .ev_stop      (ev_stop),
        .byte_valid   (byte_valid),
        .info         (info),
        .ten_bit_mode (ten_bit_mode),
        .gc_en        (gc_en),
        .slave_dis    (slave_dis),
        .result       (result),
        .addressed    (addressed)
    );

    i2c_am_stop_qual u_stop (
        .clk          (clk),
        .rst          (rst),
        .ev_stop      (ev_stop),
        .stop_qual_en (stop_qual_en),
        .addressed    (addressed),
        .stop_irq     (stop_irq)
    );

    assign addr_match = result.match;
    assign ack_req    = result.ack;
    assign gc_hit     = result.gc;

    AST_MATCH_ACKED: assert property (@(posedge clk) disable iff (rst)
        addr_match |-> ack_req) else $error("match without ack"); // R2

    AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        addr_match |=> !addr_match) else $error("match longer than one cycle"); // R2

    AST_GC_NOT_OWN: assert property (@(posedge clk) disable iff (rst)
        gc_hit |-> !addr_match) else $error("general call counted as match"); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        slave_dis |=> !ack_req && !gc_hit) else $error("disabled target acked"); // R7

endmodule

// File: tb/i2c_addr_matcher_tb.sv
module i2c_addr_matcher_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NV         = 36;

    // {req[3:0], ev[1:0] (0 byte,1 start,2 rstart,3 stop), data[7:0],
    //  cfg[3:0] {ten, gc_en, dis, stopq}, own[9:0], exp[3:0] {match, ack, gc, stop}}
    localparam logic [31:0] VEC [0:NV-1] = '{
        {4'd2,  2'd1, 8'h00, 4'b0000, 10'h2AA, 4'b0000},
        {4'd2,  2'd0, 8'h54, 4'b0000, 10'h2AA, 4'b1100}, // R2 write
        {4'd11, 2'd0, 8'h54, 4'b0000, 10'h2AA, 4'b0000}, // R11 data byte
        {4'd9,  2'd3, 8'h00, 4'b0001, 10'h2AA, 4'b0001}, // R9 addressed stop
        {4'd2,  2'd1, 8'h00, 4'b0000, 10'h2AA, 4'b0000},
        {4'd2,  2'd0, 8'h55, 4'b0000, 10'h2AA, 4'b1100}, // R2 read bit ignored
        {4'd3,  2'd1, 8'h00, 4'b0000, 10'h2AA, 4'b0000},
        {4'd3,  2'd0, 8'hF4, 4'b0000, 10'h2AA, 4'b0000}, // R3 header ignored
        {4'd8,  2'd3, 8'h00, 4'b0000, 10'h2AA, 4'b0001}, // R8 plain stop
        {4'd6,  2'd1, 8'h00, 4'b0100, 10'h2AA, 4'b0000},
        {4'd6,  2'd0, 8'h00, 4'b0100, 10'h2AA, 4'b0110}, // R6 general call
        {4'd9,  2'd3, 8'h00, 4'b0101, 10'h2AA, 4'b0000}, // R9 gc not addressed
        {4'd6,  2'd1, 8'h00, 4'b0000, 10'h2AA, 4'b0000},
        {4'd6,  2'd0, 8'h00, 4'b0000, 10'h2AA, 4'b0000}, // R6 gc disabled
        {4'd4,  2'd1, 8'h00, 4'b1000, 10'h2AA, 4'b0000},
        {4'd4,  2'd0, 8'hF4, 4'b1000, 10'h2AA, 4'b0100}, // R4 header acked
        {4'd4,  2'd0, 8'hAA, 4'b1000, 10'h2AA, 4'b1100}, // R4 low byte match
        {4'd10, 2'd2, 8'h00, 4'b1000, 10'h2AA, 4'b0000}, // R10 rstart keeps flag
        {4'd5,  2'd0, 8'hF5, 4'b1000, 10'h2AA, 4'b1100}, // R5 read header
        {4'd9,  2'd3, 8'h00, 4'b1001, 10'h2AA, 4'b0001}, // R9
        {4'd5,  2'd1, 8'h00, 4'b1000, 10'h2AA, 4'b0000},
        {4'd5,  2'd0, 8'hF5, 4'b1000, 10'h2AA, 4'b0000}, // R5 no prior match
        {4'd4,  2'd1, 8'h00, 4'b1000, 10'h2AA, 4'b0000},
        {4'd4,  2'd0, 8'hF4, 4'b1000, 10'h2AA, 4'b0100}, // R4
        {4'd4,  2'd0, 8'hAB, 4'b1000, 10'h2AA, 4'b0000}, // R4 low mismatch
        {4'd4,  2'd1, 8'h00, 4'b1000, 10'h2AA, 4'b0000},
        {4'd4,  2'd0, 8'hF6, 4'b1000, 10'h2AA, 4'b0000}, // R4 high bits mismatch
        {4'd7,  2'd1, 8'h00, 4'b0110, 10'h2AA, 4'b0000},
        {4'd7,  2'd0, 8'h54, 4'b0110, 10'h2AA, 4'b0000}, // R7 disabled
        {4'd7,  2'd1, 8'h00, 4'b0110, 10'h2AA, 4'b0000},
        {4'd7,  2'd0, 8'h00, 4'b0110, 10'h2AA, 4'b0000}, // R7 gc while disabled
        {4'd10, 2'd1, 8'h00, 4'b0000, 10'h2AA, 4'b0000},
        {4'd10, 2'd0, 8'h54, 4'b0000, 10'h2AA, 4'b1100}, // R10
        {4'd10, 2'd1, 8'h00, 4'b0000, 10'h2AA, 4'b0000}, // R10 start clears
        {4'd10, 2'd0, 8'h12, 4'b0000, 10'h2AA, 4'b0000},
        {4'd10, 2'd3, 8'h00, 4'b0001, 10'h2AA, 4'b0000}  // R10 stop not reported
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0, byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       ten_bit_mode = 1'b0, gc_en = 1'b0, slave_dis = 1'b0, stop_qual_en = 1'b0;
    logic [9:0] own_addr = 10'h2AA;
    logic       addr_match, ack_req, gc_hit, stop_irq;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_matcher dut_i (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_rstart(ev_rstart),
        .ev_stop(ev_stop), .byte_valid(byte_valid), .byte_data(byte_data),
        .ten_bit_mode(ten_bit_mode), .own_addr(own_addr), .gc_en(gc_en),
        .slave_dis(slave_dis), .stop_qual_en(stop_qual_en),
        .addr_match(addr_match), .ack_req(ack_req), .gc_hit(gc_hit), .stop_irq(stop_irq)
    );

    task automatic check(input int req, input logic [3:0] exp);
        logic [3:0] got;
        got = {addr_match, ack_req, gc_hit, stop_irq};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d outputs got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] ev, input logic [7:0] d, input logic [3:0] cfg,
                        input logic [9:0] own, input logic [3:0] exp, input int req);
        @(negedge clk);
        ev_start   = (ev == 2'd1);
        ev_rstart  = (ev == 2'd2);
        ev_stop    = (ev == 2'd3);
        byte_valid = (ev == 2'd0);
        byte_data  = d;
        {ten_bit_mode, gc_en, slave_dis, stop_qual_en} = cfg;
        own_addr   = own;
        @(negedge clk);
        check(req, exp);
        ev_start = 1'b0; ev_rstart = 1'b0; ev_stop = 1'b0; byte_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(1, 4'b0000); // R1 outputs after reset
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][27:26], VEC[i][25:18], VEC[i][17:14], VEC[i][13:4],
                 VEC[i][3:0], int'(VEC[i][31:28]));
        end
        // R1: reset in the middle of an addressed transfer clears the flag
        step(2'd1, 8'h00, 4'b0000, 10'h2AA, 4'b0000, 1);
        step(2'd0, 8'h54, 4'b0000, 10'h2AA, 4'b1100, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(1, 4'b0000);
        step(2'd3, 8'h00, 4'b0001, 10'h2AA, 4'b0000, 1);
        // R2: own_addr upper bits ignored in 7-bit mode
        step(2'd1, 8'h00, 4'b0000, 10'h12A, 4'b0000, 2);
        step(2'd0, 8'h54, 4'b0000, 10'h12A, 4'b1100, 2);
        // R11: a data byte equal to the address after the match stays quiet
        step(2'd0, 8'h54, 4'b0000, 10'h12A, 4'b0000, 11);
        step(2'd3, 8'h00, 4'b0000, 10'h12A, 4'b0001, 8); // R8
        // R11: bytes after a stop, before any start, never match
        step(2'd0, 8'h54, 4'b0000, 10'h12A, 4'b0000, 11);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired got running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule